// File: doc/BRIEF.md
# Multi-Channel Shared-Memory Packet FIFO

This block buffers a stream that carries several logical channels in one inferred single-clock RAM. The RAM is cut into fixed segments, one per channel, and each segment works as its own FIFO. Incoming beats carry a channel number, packet delimiters and an error field, and each beat is stored in the segment of its channel. A consumer names a channel on a request port, and the block presents the head beat of that channel on a streaming source.

Packet-buffer mode holds a packet back until its last beat has been stored, so the consumer only ever sees whole packets. If drop-on-error is also enabled, a packet that carried a nonzero error on any of its beats is discarded. Without packet-buffer mode, a channel is offered to the output once its fill level reaches a programmable section threshold. A small register port holds the threshold registers and returns the fill level of each channel. Two pairs of warning flags per channel compare the fill level against shared almost-full and almost-empty thresholds.

Top module: `mcf_shared_fifo`

## Requirements
- R1: Each of the N_CH channels (N_CH one of 1, 2, 4, 8, 16) owns a segment of 2^ADDR_W beats, and beats written to one channel come out of that channel only, in the order they were accepted.
- R2: While the request is valid for channel c and c has available data, src_valid is high and src_chan equals c. The source shows c's oldest beat (data, sop, eop, err), and that beat is removed on a cycle with src_valid and src_ready both high.
- R3: A register read with csr_addr[CSR_AW-1]=1 returns the fill level of the channel given by the low CH_W address bits. The fill level is the number of beats stored and not yet read, counting the beats of an incomplete packet, and ranges from 0 to 2^ADDR_W.
- R4: snk_ready is low whenever the segment of snk_chan holds 2^ADDR_W beats. A beat that is held while the segment is full is accepted unchanged once a read frees space.
- R5: With PKT_BUF=1, a channel shows no beat of a packet at the source until that packet's end-of-packet beat has been accepted.
- R6: With PKT_BUF=1 and DROP_ERR=1, a packet in which any beat had a nonzero snk_err is discarded at its end-of-packet beat, and its channel's fill level returns to its value before the packet. With PKT_BUF=0, DROP_ERR has no effect.
- R7: With PKT_BUF=1 and DROP_ERR=0, a packet carrying an error is delivered whole, and each beat keeps its own error value.
- R8: With PKT_BUF=0, a channel is available only while its fill level is nonzero and is at least the section threshold (register offset 4, reset value 1).
- R9: For each channel, af1 = fill >= offset 0, af2 = fill >= offset 1, ae1 = fill <= offset 2 and ae2 = fill <= offset 3. The reset values are 2^ADDR_W, 2^ADDR_W-2, 0 and 2. A pair is held low when N_AF (or N_AE) is below the pair's index.
- R10: A register with csr_addr[CSR_AW-1]=0 and low bits 0 to 4 is written with csr_wdata on a cycle where csr_write is high, and it reads back that value at the same address.
- R11: With USE_REQ=0, the source serves channel 0 only, and req_valid and req_chan have no effect.
- R12: After reset every channel is empty: snk_ready is high for every channel, src_valid is low, and the flags take their values for a fill level of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snk_valid | input | 1 | Sink beat valid |
| snk_ready | output | 1 | Sink can accept a beat for snk_chan |
| snk_data | input | DATA_W | Sink beat data |
| snk_chan | input | CH_W | Channel of the sink beat |
| snk_sop | input | 1 | First beat of a packet |
| snk_eop | input | 1 | Last beat of a packet |
| snk_err | input | ERR_W | Error field of the sink beat |
| req_valid | input | 1 | Consumer requests a channel |
| req_chan | input | CH_W | Requested channel |
| src_ready | input | 1 | Consumer accepts the source beat |
| src_valid | output | 1 | Source beat valid |
| src_data | output | DATA_W | Source beat data |
| src_chan | output | CH_W | Channel of the source beat |
| src_sop | output | 1 | Source first beat of packet |
| src_eop | output | 1 | Source last beat of packet |
| src_err | output | ERR_W | Source error field |
| csr_write | input | 1 | Register write strobe |
| csr_addr | input | CSR_AW | Register address |
| csr_wdata | input | ADDR_W+1 | Register write data |
| csr_rdata | output | ADDR_W+1 | Register read data |
| af1 | output | N_CH | Almost-full flag, threshold 1, per channel |
| af2 | output | N_CH | Almost-full flag, threshold 2 (early), per channel |
| ae1 | output | N_CH | Almost-empty flag, threshold 1, per channel |
| ae2 | output | N_CH | Almost-empty flag, threshold 2 (early), per channel |

## Verification
The properties assume that no packet is longer than one segment in packet-buffer mode, because such a packet can never complete. They also assume that an unserved request stays put long enough for the head-hold check to have meaning. The stimulus keeps every packet at three beats or fewer, against segments of eight. Overflow is exercised only on the instance without packet buffering, where a full segment drains normally. Request and channel inputs change only between clock edges, so each property sees a settled request when it samples.

// File: rtl/mcf_pkg.sv
// Shared types for the multi-channel shared-memory FIFO.
// Assumes nothing beyond SystemVerilog-2017 package support.
package mcf_pkg;
    // Offsets of the threshold registers in the register port
    typedef enum logic [2:0] {
        REG_AF1  = 3'd0,
        REG_AF2  = 3'd1,
        REG_AE1  = 3'd2,
        REG_AE2  = 3'd3,
        REG_SECT = 3'd4
    } csr_reg_e;

    localparam int N_THR = 5;

    // Index width that never drops below one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mcf_ram.sv
// Single-clock storage shared by all channel segments.
// One write port, one asynchronous read port; no reset of contents.
module mcf_ram #(
    parameter int WORD_W = 11,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int WORDS = 2 ** AW;

    logic [WORD_W-1:0] mem [WORDS];

    // Store one beat per cycle
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mcf_chan.sv
// Pointer set of one channel segment: write, committed-write and read.
// Assumes the caller never writes while full nor reads while unavailable,
// and that packets fit within one segment when PKT_BUF is set.
module mcf_chan #(
    parameter int ADDR_W   = 3,
    parameter int PKT_BUF  = 1,
    parameter int DROP_ERR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_eop,
    input  logic              wr_err,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   sect_thr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   fill,
    output logic              full,
    output logic              avail
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 2 ** ADDR_W;
    localparam bit PKT   = (PKT_BUF != 0);
    localparam bit DROP  = PKT && (DROP_ERR != 0);

    logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr;
    logic          bad;
    logic          drop;

    assign fill    = wr_ptr - rd_ptr;
    assign full    = (fill == PW'(DEPTH));
    assign wr_addr = wr_ptr[ADDR_W-1:0];
    assign rd_addr = rd_ptr[ADDR_W-1:0];
    assign drop    = DROP && wr_en && wr_eop && (bad || wr_err);

    // Advance pointers, commit finished packets, roll back dropped ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            cmt_ptr <= '0;
            rd_ptr  <= '0;
            bad     <= 1'b0;
        end else begin
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            if (wr_en) begin
                if (drop) begin
                    wr_ptr <= cmt_ptr;
                end else begin
                    wr_ptr <= wr_ptr + 1'b1;
                    if (!PKT || wr_eop) cmt_ptr <= wr_ptr + 1'b1;
                end
                if (wr_eop)      bad <= 1'b0;
                else if (wr_err) bad <= 1'b1;
            end
        end
    end

    // Offer data: whole packets in packet mode, else past the section level
    always_comb begin
        if (PKT) avail = (cmt_ptr != rd_ptr);
        else     avail = (fill != '0) && (fill >= sect_thr);
    end
endmodule

// File: rtl/mcf_shared_fifo.sv
// Multi-channel FIFO over one shared RAM with a fixed segment per channel.
// Sink beats go to the segment of snk_chan; the source shows the head of the
// requested channel. A register port holds thresholds and reports fill levels.
// Assumes ERR_W >= 1 and N_CH a power of two up to 16.
module mcf_shared_fifo
    import mcf_pkg::*;
#(
    parameter int N_CH     = 4,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int ERR_W    = 1,
    parameter int PKT_BUF  = 1,
    parameter int DROP_ERR = 1,
    parameter int USE_REQ  = 1,
    parameter int N_AF     = 2,
    parameter int N_AE     = 2,
    localparam int CH_W    = idx_w(N_CH),
    localparam int PW      = ADDR_W + 1,
    localparam int CSR_AW  = ((CH_W > 3) ? CH_W : 3) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snk_valid,
    output logic              snk_ready,
    input  logic [DATA_W-1:0] snk_data,
    input  logic [CH_W-1:0]   snk_chan,
    input  logic              snk_sop,
    input  logic              snk_eop,
    input  logic [ERR_W-1:0]  snk_err,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              src_ready,
    output logic              src_valid,
    output logic [DATA_W-1:0] src_data,
    output logic [CH_W-1:0]   src_chan,
    output logic              src_sop,
    output logic              src_eop,
    output logic [ERR_W-1:0]  src_err,
    input  logic              csr_write,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [PW-1:0]     csr_wdata,
    output logic [PW-1:0]     csr_rdata,
    output logic [N_CH-1:0]   af1,
    output logic [N_CH-1:0]   af2,
    output logic [N_CH-1:0]   ae1,
    output logic [N_CH-1:0]   ae2
);
    localparam int NSLOT  = 2 ** CH_W;
    localparam int DEPTH  = 2 ** ADDR_W;
    localparam int WORD_W = DATA_W + ERR_W + 2;
    localparam int MEM_AW = CH_W + ADDR_W;

    logic [ADDR_W-1:0] wr_addr [NSLOT];
    logic [ADDR_W-1:0] rd_addr [NSLOT];
    logic [PW-1:0]     fill    [NSLOT];
    logic [NSLOT-1:0]  full_v, avail_v;
    logic [NSLOT*PW-1:0] fill_flat;
    logic [PW-1:0]     thr [N_THR];
    logic [CH_W-1:0]   sel_ch;
    logic              req_ok, acc, fire;
    logic [WORD_W-1:0] rword;
    logic [2:0]        csr_idx;

    assign sel_ch    = (USE_REQ != 0) ? req_chan : '0;
    assign req_ok    = (USE_REQ != 0) ? req_valid : 1'b1;
    assign snk_ready = !full_v[snk_chan];
    assign acc       = snk_valid && snk_ready;
    assign src_valid = req_ok && avail_v[sel_ch];
    assign fire      = src_valid && src_ready;
    assign src_chan  = sel_ch;
    assign {src_sop, src_eop, src_err, src_data} = rword;

    // One pointer set per real channel; padding slots look full and empty
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i < N_CH) begin : g_ch
            mcf_chan #(.ADDR_W(ADDR_W), .PKT_BUF(PKT_BUF), .DROP_ERR(DROP_ERR)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (acc && (snk_chan == CH_W'(i))),
                .wr_eop   (snk_eop),
                .wr_err   (|snk_err),
                .rd_en    (fire && (sel_ch == CH_W'(i))),
                .sect_thr (thr[REG_SECT]),
                .wr_addr  (wr_addr[i]),
                .rd_addr  (rd_addr[i]),
                .fill     (fill[i]),
                .full     (full_v[i]),
                .avail    (avail_v[i])
            );
        end else begin : g_pad
            assign wr_addr[i] = '0;
            assign rd_addr[i] = '0;
            assign fill[i]    = '0;
            assign full_v[i]  = 1'b1;
            assign avail_v[i] = 1'b0;
        end
        assign fill_flat[i*PW +: PW] = fill[i];
    end

    mcf_ram #(.WORD_W(WORD_W), .AW(MEM_AW)) u_ram (
        .clk   (clk),
        .we    (acc),
        .waddr ({snk_chan, wr_addr[snk_chan]}),
        .wdata ({snk_sop, snk_eop, snk_err, snk_data}),
        .raddr ({sel_ch, rd_addr[sel_ch]}),
        .rdata (rword)
    );

    assign csr_idx = csr_addr[2:0];

    // Threshold registers: reset defaults, written through the register port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr[REG_AF1]  <= PW'(DEPTH);
            thr[REG_AF2]  <= PW'(DEPTH - 2);
            thr[REG_AE1]  <= '0;
            thr[REG_AE2]  <= PW'(2);
            thr[REG_SECT] <= PW'(1);
        end else if (csr_write && !csr_addr[CSR_AW-1] && (csr_idx <= 3'd4)) begin
            thr[csr_idx] <= csr_wdata;
        end
    end

    // Register read: fill levels in the upper half, thresholds in the lower
    always_comb begin
        if (csr_addr[CSR_AW-1])   csr_rdata = fill[csr_addr[CH_W-1:0]];
        else if (csr_idx <= 3'd4) csr_rdata = thr[csr_idx];
        else                      csr_rdata = '0;
    end

    // Warning flags per channel, each pair present only when enabled
    for (genvar i = 0; i < N_CH; i++) begin : g_flag
        assign af1[i] = (N_AF >= 1) && (fill[i] >= thr[REG_AF1]);
        assign af2[i] = (N_AF >= 2) && (fill[i] >= thr[REG_AF2]);
        assign ae1[i] = (N_AE >= 1) && (fill[i] <= thr[REG_AE1]);
        assign ae2[i] = (N_AE >= 2) && (fill[i] <= thr[REG_AE2]);
    end
endmodule

// File: rtl/mcf_shared_fifo_chk.sv
// Property checker for mcf_shared_fifo, attached by bind below.
// Assumes packets fit one segment and requests change only between edges.
module mcf_shared_fifo_chk #(
    parameter int N_CH     = 4,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int ERR_W    = 1,
    parameter int PKT_BUF  = 1,
    parameter int DROP_ERR = 1,
    parameter int USE_REQ  = 1,
    parameter int CH_W     = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic [CH_W-1:0]              req_chan,
    input logic                         src_valid,
    input logic                         src_ready,
    input logic [DATA_W-1:0]            src_data,
    input logic [CH_W-1:0]              src_chan,
    input logic [ERR_W-1:0]             src_err,
    input logic [(2**CH_W)*(ADDR_W+1)-1:0] fill_flat
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 2 ** ADDR_W;

    if (USE_REQ != 0) begin : g_req
        // R2: the source only offers the channel that was requested
        a_r2_chan_match: assert property (@(posedge clk) disable iff (!rst_n)
            src_valid |-> (req_valid && (src_chan == req_chan)));
    end else begin : g_noreq
        // R11: without a request port only channel 0 reaches the source
        a_r11_chan_zero: assert property (@(posedge clk) disable iff (!rst_n)
            src_valid |-> (src_chan == '0));
    end

    // R2: an unaccepted head beat stays offered and unchanged
    a_r2_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_valid && !src_ready) && $stable(req_valid) && $stable(req_chan))
        |-> (src_valid && $stable(src_data)));

    if ((PKT_BUF != 0) && (DROP_ERR != 0)) begin : g_drop
        // R6: dropped packets never show their error at the source
        a_r6_no_err_out: assert property (@(posedge clk) disable iff (!rst_n)
            src_valid |-> (src_err == '0));
    end

    for (genvar i = 0; i < 2 ** CH_W; i++) begin : g_fill
        // R3: fill stays within a segment and grows by at most one per cycle
        a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, fill_flat[i*PW +: PW]} <= (PW+1)'(DEPTH)) &&
            ({1'b0, fill_flat[i*PW +: PW]} <= {1'b0, $past(fill_flat[i*PW +: PW])} + 1'b1));
    end
endmodule

bind mcf_shared_fifo mcf_shared_fifo_chk #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W),
    .PKT_BUF(PKT_BUF), .DROP_ERR(DROP_ERR), .USE_REQ(USE_REQ), .CH_W(CH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .src_chan(src_chan), .src_err(src_err), .fill_flat(fill_flat)
);

// File: tb/mcf_shared_fifo_bench.sv
`timescale 1ns/1ps
module mcf_shared_fifo_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Instances A (drop on) and B (drop off) share all inputs except src_ready
    logic       s_valid = 0, s_sop = 0, s_eop = 0;
    logic [7:0] s_data = 0;
    logic [1:0] s_chan = 0;
    logic [0:0] s_err = 0;
    logic       r_valid = 0, a_src_ready = 0, b_src_ready = 0;
    logic [1:0] r_chan = 0;
    logic       csr_write = 0;
    logic [3:0] csr_addr = 0, csr_wdata = 0;

    logic       a_snk_ready, a_src_valid, a_src_sop, a_src_eop;
    logic [7:0] a_src_data;
    logic [1:0] a_src_chan;
    logic [0:0] a_src_err;
    logic [3:0] a_rdata, a_af1, a_af2, a_ae1, a_ae2;
    logic       b_snk_ready, b_src_valid, b_src_sop, b_src_eop;
    logic [7:0] b_src_data;
    logic [1:0] b_src_chan;
    logic [0:0] b_src_err;
    logic [3:0] b_rdata, b_af1, b_af2, b_ae1, b_ae2;

    // Instance C: no packet buffering, no request port, two channels
    logic       c_valid = 0, c_sop = 0, c_eop = 0, c_chan = 0, c_req_chan = 1;
    logic [7:0] c_data = 0;
    logic [0:0] c_err = 0;
    logic       c_req_valid = 0, c_src_ready = 0, c_csr_write = 0;
    logic [3:0] c_csr_addr = 0, c_csr_wdata = 0;
    logic       c_snk_ready, c_src_valid, c_src_sop, c_src_eop, c_src_chan;
    logic [7:0] c_src_data;
    logic [0:0] c_src_err;
    logic [3:0] c_rdata;
    logic [1:0] c_af1, c_af2, c_ae1, c_ae2;

    mcf_shared_fifo #(.N_CH(4), .ADDR_W(3), .PKT_BUF(1), .DROP_ERR(1)) u_mcf_shared_fifo (
        .clk(clk), .rst_n(rst_n), .snk_valid(s_valid), .snk_ready(a_snk_ready),
        .snk_data(s_data), .snk_chan(s_chan), .snk_sop(s_sop), .snk_eop(s_eop),
        .snk_err(s_err), .req_valid(r_valid), .req_chan(r_chan), .src_ready(a_src_ready),
        .src_valid(a_src_valid), .src_data(a_src_data), .src_chan(a_src_chan),
        .src_sop(a_src_sop), .src_eop(a_src_eop), .src_err(a_src_err),
        .csr_write(csr_write), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(a_rdata), .af1(a_af1), .af2(a_af2), .ae1(a_ae1), .ae2(a_ae2));

    mcf_shared_fifo #(.N_CH(4), .ADDR_W(3), .PKT_BUF(1), .DROP_ERR(0)) u_mcf_shared_fifo_b (
        .clk(clk), .rst_n(rst_n), .snk_valid(s_valid), .snk_ready(b_snk_ready),
        .snk_data(s_data), .snk_chan(s_chan), .snk_sop(s_sop), .snk_eop(s_eop),
        .snk_err(s_err), .req_valid(r_valid), .req_chan(r_chan), .src_ready(b_src_ready),
        .src_valid(b_src_valid), .src_data(b_src_data), .src_chan(b_src_chan),
        .src_sop(b_src_sop), .src_eop(b_src_eop), .src_err(b_src_err),
        .csr_write(csr_write), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(b_rdata), .af1(b_af1), .af2(b_af2), .ae1(b_ae1), .ae2(b_ae2));

    mcf_shared_fifo #(.N_CH(2), .ADDR_W(3), .PKT_BUF(0), .DROP_ERR(1), .USE_REQ(0)) u_mcf_shared_fifo_c (
        .clk(clk), .rst_n(rst_n), .snk_valid(c_valid), .snk_ready(c_snk_ready),
        .snk_data(c_data), .snk_chan(c_chan), .snk_sop(c_sop), .snk_eop(c_eop),
        .snk_err(c_err), .req_valid(c_req_valid), .req_chan(c_req_chan), .src_ready(c_src_ready),
        .src_valid(c_src_valid), .src_data(c_src_data), .src_chan(c_src_chan),
        .src_sop(c_src_sop), .src_eop(c_src_eop), .src_err(c_src_err),
        .csr_write(c_csr_write), .csr_addr(c_csr_addr), .csr_wdata(c_csr_wdata),
        .csr_rdata(c_rdata), .af1(c_af1), .af2(c_af2), .ae1(c_ae1), .ae2(c_ae2));

    // Vector: [21:20] chan [19:12] data [11] sop [10] eop [9] err
    //         [8:5] fill A after beat [4:1] fill B after beat [0] A shows data
    localparam logic [21:0] VEC [9] = '{
        {2'd0, 8'h10, 1'b1, 1'b0, 1'b0, 4'd1, 4'd1, 1'b0},
        {2'd0, 8'h11, 1'b0, 1'b1, 1'b0, 4'd2, 4'd2, 1'b1},
        {2'd1, 8'h20, 1'b1, 1'b0, 1'b1, 4'd1, 4'd1, 1'b0},
        {2'd1, 8'h21, 1'b0, 1'b1, 1'b0, 4'd0, 4'd2, 1'b0},
        {2'd2, 8'h30, 1'b1, 1'b1, 1'b0, 4'd1, 4'd1, 1'b1},
        {2'd1, 8'h22, 1'b1, 1'b1, 1'b0, 4'd1, 4'd3, 1'b1},
        {2'd3, 8'h40, 1'b1, 1'b0, 1'b0, 4'd1, 4'd1, 1'b0},
        {2'd3, 8'h41, 1'b0, 1'b1, 1'b1, 4'd0, 4'd2, 1'b0},
        {2'd3, 8'h42, 1'b1, 1'b1, 1'b0, 4'd1, 4'd3, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_ab(input logic [1:0] ch, input logic [7:0] d,
                          input logic sop, input logic eop, input logic err);
        @(negedge clk);
        s_valid = 1; s_chan = ch; s_data = d; s_sop = sop; s_eop = eop; s_err = err;
        @(negedge clk);
        s_valid = 0;
    endtask

    task automatic rd_a(input logic [1:0] ch, input logic [7:0] d, input logic sop, input logic eop);
        @(negedge clk);
        r_valid = 1; r_chan = ch; a_src_ready = 1;
        #1;
        chk("R2 A src_valid", a_src_valid, 1);
        chk("R2 R1 A head beat", {a_src_chan, a_src_data, a_src_sop, a_src_eop},
            {ch, d, sop, eop});
        @(negedge clk);
        a_src_ready = 0; r_valid = 0;
    endtask

    task automatic rd_b(input logic [1:0] ch, input logic [7:0] d, input logic err);
        @(negedge clk);
        r_valid = 1; r_chan = ch; b_src_ready = 1;
        #1;
        chk("R7 B beat with error kept", {b_src_valid, b_src_data, b_src_err}, {1'b1, d, err});
        @(negedge clk);
        b_src_ready = 0; r_valid = 0;
    endtask

    task automatic put_c(input logic ch, input logic [7:0] d, input logic err);
        @(negedge clk);
        c_valid = 1; c_chan = ch; c_data = d; c_err = err;
        @(negedge clk);
        c_valid = 0;
    endtask

    task automatic rd_c(input logic [7:0] d, input logic err, input string tag);
        @(negedge clk);
        c_src_ready = 1;
        #1;
        chk(tag, {c_src_valid, c_src_chan, c_src_data, c_src_err}, {1'b1, 1'b0, d, err});
        @(negedge clk);
        c_src_ready = 0;
    endtask

    task automatic csr_ab(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        csr_write = 1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_write = 0;
    endtask

    task automatic csr_c(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        c_csr_write = 1; c_csr_addr = a; c_csr_wdata = d;
        @(negedge clk);
        c_csr_write = 0;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R12: reset state
        r_valid = 1; r_chan = 0; csr_addr = 4'h8;
        #1;
        chk("R12 snk_ready after reset", a_snk_ready, 1);
        chk("R12 src_valid after reset", a_src_valid, 0);
        chk("R12 flags after reset", {a_af1, a_af2, a_ae1, a_ae2}, {4'h0, 4'h0, 4'hF, 4'hF});
        chk("R12 R3 fill after reset", a_rdata, 0);
        r_valid = 0;

        // Table walk: R1 segments, R3 fill, R5 visibility, R6 drop, R7 keep
        for (int i = 0; i < 9; i++) begin
            logic [21:0] v;
            v = VEC[i];
            put_ab(v[21:20], v[19:12], v[11], v[10], v[9]);
            csr_addr = {2'b10, v[21:20]};
            r_valid = 1; r_chan = v[21:20];
            #1;
            chk("R3/R6 A fill", a_rdata, {28'd0, v[8:5]});
            chk("R3/R7 B fill", b_rdata, {28'd0, v[4:1]});
            chk("R5 A packet visible", a_src_valid, v[0]);
            r_valid = 0;
        end

        // R9 and R10: program thresholds and compare flags (fills 2,1,1,1)
        csr_ab(4'h0, 4'd2);
        csr_ab(4'h1, 4'd1);
        csr_ab(4'h2, 4'd1);
        csr_ab(4'h3, 4'd2);
        csr_addr = 4'h0;
        #1;
        chk("R10 threshold readback", a_rdata, 2);
        chk("R9 af1", a_af1, 4'b0001);
        chk("R9 af2", a_af2, 4'b1111);
        chk("R9 ae1", a_ae1, 4'b1110);
        chk("R9 ae2", a_ae2, 4'b1111);

        // R2 R1: drain A per channel
        rd_a(2'd0, 8'h10, 1, 0);
        rd_a(2'd0, 8'h11, 0, 1);
        rd_a(2'd1, 8'h22, 1, 1);
        rd_a(2'd2, 8'h30, 1, 1);
        rd_a(2'd3, 8'h42, 1, 1);
        @(negedge clk);
        r_valid = 1; r_chan = 2'd0;
        #1;
        chk("R2 A empty after drain", a_src_valid, 0);
        chk("R9 flags after drain", {a_af2, a_ae1}, {4'h0, 4'hF});
        r_valid = 0;

        // R7: B forwards error packets whole
        rd_b(2'd1, 8'h20, 1);
        rd_b(2'd1, 8'h21, 0);
        rd_b(2'd1, 8'h22, 0);
        rd_b(2'd3, 8'h40, 0);
        rd_b(2'd3, 8'h41, 1);
        rd_b(2'd3, 8'h42, 0);

        // R8: section threshold on C; R11 request inputs ignored
        csr_c(4'h4, 4'd3);
        c_req_valid = 0; c_req_chan = 1;
        put_c(0, 8'h01, 0);
        #1 chk("R8 below section threshold", c_src_valid, 0);
        put_c(0, 8'h02, 0);
        #1 chk("R8 below section threshold", c_src_valid, 0);
        put_c(0, 8'h03, 1);
        #1 chk("R8 R11 at section threshold", {c_src_valid, c_src_chan}, {1'b1, 1'b0});
        csr_c(4'h4, 4'd1);
        put_c(1, 8'h55, 0);
        c_csr_addr = 4'h9;
        #1 chk("R1 C channel 1 fill", c_rdata, 1);
        rd_c(8'h01, 0, "R11 C serves channel 0");
        rd_c(8'h02, 0, "R11 C serves channel 0");
        rd_c(8'h03, 1, "R6 no drop without packet mode");
        #1 chk("R11 channel 1 never served", c_src_valid, 0);

        // R4: fill channel 0 of C, hold a beat while full
        for (int k = 0; k < 8; k++) put_c(0, 8'h80 + 8'(k), 0);
        @(negedge clk);
        c_valid = 1; c_chan = 0; c_data = 8'hAA; c_err = 0;
        #1 chk("R4 ready low when full", c_snk_ready, 0);
        c_chan = 1;
        #0.5 chk("R4 other channel ready", c_snk_ready, 1);
        c_chan = 0;
        @(negedge clk);
        c_src_ready = 1;
        #1 chk("R4 head while full", c_src_data, 8'h80);
        @(negedge clk);
        c_src_ready = 0;
        @(negedge clk);
        c_valid = 0;
        c_csr_addr = 4'h8;
        #1 chk("R4 R3 fill after held beat", c_rdata, 8);
        for (int k = 1; k < 8; k++) rd_c(8'h80 + 8'(k), 0, "R4 drain order");
        rd_c(8'hAA, 0, "R4 held beat not lost");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule